// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides when an analog-to-digital converter should begin a new conversion on its own. A small configuration register holds a 3-bit code that picks one of eight event flags: the converter's own conversion-complete flag (free-running operation), an analog comparator flag, an external interrupt flag, compare and overflow flags from two timers, and a timer capture flag. A rising edge on the chosen flag produces a one-clock start pulse for the conversion engine. The pulse is issued only while both the auto-trigger enable and the converter enable are high.

Edge detection is done on the output of the source multiplexer rather than on each source separately. Reprogramming the selection can therefore create an edge by itself. Moving from a source whose flag is low to a source whose flag is high fires a start. Moving to free-running mode never does, because the write that selects code 000 preloads the edge history as high. While either enable is low, the edge history still tracks the selected flag. Turning the enables on while that flag is already high therefore starts nothing.

Top module: `adc_trig_sel`

## Requirements
- R1: After a synchronous active-low reset, the configuration read value is 0x00 (select code 000) and no start pulse is issued while all flags stay low.
- R2: A cycle with `cfg_wr_en` high loads `cfg_wr_sel` into the select code, which appears on `cfg_rd_data[2:0]` from the next cycle on. Bits 7:3 of `cfg_rd_data` always read zero. Without a write, the code holds.
- R3: Select code k picks `src_flags[k]`. The mapping is: 0 conversion complete (free-running), 1 comparator, 2 external interrupt 0, 3 timer 0 compare A, 4 timer 0 overflow, 5 timer 1 compare B, 6 timer 1 overflow, 7 timer 1 capture.
- R4: With both enables high, a low-to-high change of the selected flag raises `start_pulse` in the cycle where the flag is first high, for exactly one clock. A flag that stays high gives no further pulse.
- R5: Edges on flags other than the selected one never cause a pulse.
- R6: While `auto_en` is low, no pulse is issued.
- R7: While `conv_en` is low, no pulse is issued.
- R8: The edge history follows the selected flag while the block is disabled. Enabling the block while the selected flag is already high produces no pulse.
- R9: With both enables high, rewriting the selection from a source whose flag is low to a nonzero code whose flag is high produces one pulse in the cycle after the write.
- R10: A write that selects code 000 never causes a pulse in the following cycle, even when the conversion-complete flag is high.
- R11: A high-to-low change of the selected flag produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the select code |
| cfg_wr_sel | input | 3 | Select code to write |
| cfg_rd_data | output | 8 | Configuration register read value |
| auto_en | input | 1 | Auto-trigger enable |
| conv_en | input | 1 | Converter enable |
| src_flags | input | 8 | Event flags, bit index equals select code |
| start_pulse | output | 1 | One-cycle conversion start request |

## Verification
The hardest situations to reach are the selection-change edges. In these, the flag levels stay constant and only the select code moves, so the edge exists only in the history register. The bench sweeps every ordered pair of old and new codes and every low/high combination of the two flags involved, under all four enable combinations. It first settles the history on the old source, then writes the new code while holding the flags steady, and compares the following cycle's pulse with a model built from the requirements. This covers switches into code 000 with the complete flag high. It also covers switches made while disabled that are followed by an enable.

// File: rtl/adc_trig_pkg.sv
// Package: shared constants and source codes for the auto-trigger selector.
// Assumes eight sources; the code value equals the source's bit position.
package adc_trig_pkg;
    localparam int TRIG_NUM_SRC = 8;
    localparam int TRIG_SEL_W   = 3;
    localparam int TRIG_CFG_W   = 8;

    typedef enum logic [TRIG_SEL_W-1:0] {
        SRC_FREE_RUN = 3'd0,
        SRC_ACMP     = 3'd1,
        SRC_EXTINT0  = 3'd2,
        SRC_T0_CMPA  = 3'd3,
        SRC_T0_OVF   = 3'd4,
        SRC_T1_CMPB  = 3'd5,
        SRC_T1_OVF   = 3'd6,
        SRC_T1_CAPT  = 3'd7
    } trig_src_e;
endpackage

// File: rtl/adc_trig_cfg.sv
// Module: select-code register. Holds the code, loads it on a write strobe
// and presents it zero-extended on the read port (reserved bits read 0).
// Assumes a single writer and synchronous active-low reset.
module adc_trig_cfg #(
    parameter int SEL_W = 3,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output logic [SEL_W-1:0] sel,
    output logic [CFG_W-1:0] rd_data
);
    localparam int RSVD_W = CFG_W - SEL_W;

    logic [SEL_W-1:0] sel_q;

    // Purpose: load or hold the select code.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_en)  sel_q <= wr_sel;
    end

    assign sel     = sel_q;
    assign rd_data = {{RSVD_W{1'b0}}, sel_q};

    assert_reset_sel_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[SEL_W-1:0] == $past(wr_sel)));

    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/adc_trig_mux.sv
// Module: source multiplexer built as a decoded AND-OR tree, one leg per
// source. Assumes NUM_SRC fits in SEL_W bits.
module adc_trig_mux #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 3
) (
    input  logic [NUM_SRC-1:0] flags,
    input  logic [SEL_W-1:0]   sel,
    output logic               picked
);
    logic [NUM_SRC-1:0] leg;

    // Purpose: one gated leg per source, enabled when the code matches.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_leg
        assign leg[g] = flags[g] & (sel == SEL_W'(g));
    end

    assign picked = |leg;

    // R3: at most one leg can be active.
    always_comb begin
        assert_one_leg_R3: assert ($onehot0(leg));
    end
endmodule

// File: rtl/adc_trig_edge.sv
// Module: rising-edge detector with a preloadable history bit. The history
// follows the input every cycle unless force_hi sets it high.
// Assumes the input is synchronous to clk.
module adc_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic force_hi,
    output logic rise
);
    logic hist_q;

    // Purpose: remember the previous sample, or preload it high.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= 1'b0;
        else if (force_hi) hist_q <= 1'b1;
        else               hist_q <= sig;
    end

    assign rise = sig & ~hist_q;

    assert_rise_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/adc_trig_sel.sv
// Module: top of the auto-trigger selector. Picks a flag by select code,
// detects its rising edge (including edges made by reselection, except into
// code 000) and gates the result with both enables.
// Assumes all inputs are synchronous to clk.
module adc_trig_sel
    import adc_trig_pkg::*;
#(
    parameter int NUM_SRC = TRIG_NUM_SRC,
    parameter int SEL_W   = $clog2(NUM_SRC),
    parameter int CFG_W   = TRIG_CFG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [SEL_W-1:0]   cfg_wr_sel,
    output logic [CFG_W-1:0]   cfg_rd_data,
    input  logic               auto_en,
    input  logic               conv_en,
    input  logic [NUM_SRC-1:0] src_flags,
    output logic               start_pulse
);
    logic [SEL_W-1:0] sel;
    logic             picked;
    logic             free_wr;
    logic             rise;

    adc_trig_cfg #(.SEL_W(SEL_W), .CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .sel     (sel),
        .rd_data (cfg_rd_data)
    );

    adc_trig_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
        .flags  (src_flags),
        .sel    (sel),
        .picked (picked)
    );

    // Purpose: a write into free-running mode preloads the edge history.
    assign free_wr = cfg_wr_en & (cfg_wr_sel == SEL_W'(SRC_FREE_RUN));

    adc_trig_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig      (picked),
        .force_hi (free_wr),
        .rise     (rise)
    );

    // Purpose: pass the edge only when both enables are set.
    assign start_pulse = rise & auto_en & conv_en;

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_free_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        free_wr |=> !start_pulse);

    assert_pulse_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> src_flags[sel]);
endmodule

// File: tb/adc_trig_sel_tb.sv
`timescale 1ns/1ps
module adc_trig_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [2:0] cfg_wr_sel = 3'd0;
    logic [7:0] cfg_rd_data;
    logic       auto_en = 1'b0;
    logic       conv_en = 1'b0;
    logic [7:0] src_flags = 8'd0;
    logic       start_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int m_sel = 0;
    bit m_hist = 1'b0;

    always #2.5 clk = ~clk;

    adc_trig_sel u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_rd_data(cfg_rd_data), .auto_en(auto_en), .conv_en(conv_en),
        .src_flags(src_flags), .start_pulse(start_pulse)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare mid-cycle, advance the model.
    task automatic cyc(input logic [7:0] f, input bit wr, input logic [2:0] ws,
                       input bit ae, input bit ce, input string req);
        logic exp_p;
        @(negedge clk);
        src_flags = f; cfg_wr_en = wr; cfg_wr_sel = ws; auto_en = ae; conv_en = ce;
        #1;
        exp_p = ae & ce & f[m_sel] & ~m_hist;
        check({7'd0, start_pulse}, {7'd0, exp_p}, req);
        check(cfg_rd_data, 8'(m_sel), "R2");
        m_hist = (wr && ws == 3'd0) ? 1'b1 : f[m_sel];
        if (wr) m_sel = int'(ws);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        #1;
        check(cfg_rd_data, 8'h00, "R1");
        check({7'd0, start_pulse}, 8'h00, "R1");
        cyc(8'h00, 0, 0, 1, 1, "R1");

        // R3: each code picks its own flag and edges fire a pulse (R4)
        for (int k = 0; k < 8; k++) begin
            cyc(8'h00, 1, 3'(k), 1, 1, "R3");
            cyc(8'h00, 0, 0, 1, 1, "R3");
            check(cfg_rd_data, 8'(k), "R3");
            cyc(8'(1 << k), 0, 0, 1, 1, "R3");
            cyc(8'(1 << k), 0, 0, 1, 1, "R4");
            cyc(8'h00, 0, 0, 1, 1, "R11");
        end

        // R5: other flags toggle while code 4 is selected
        cyc(8'h00, 1, 3'd4, 1, 1, "R5");
        for (int p = 0; p < 8; p++) begin
            cyc(8'hEF & 8'(p * 37), 0, 0, 1, 1, "R5");
            cyc(8'h00, 0, 0, 1, 1, "R5");
        end

        // R6 / R7: gated edges
        cyc(8'h00, 1, 3'd2, 1, 1, "R6");
        cyc(8'h04, 0, 0, 0, 1, "R6");
        cyc(8'h00, 0, 0, 0, 1, "R6");
        cyc(8'h04, 0, 0, 1, 0, "R7");
        cyc(8'h00, 0, 0, 1, 0, "R7");

        // R8: enable with flag already high
        cyc(8'h00, 1, 3'd5, 0, 0, "R8");
        cyc(8'h20, 0, 0, 0, 0, "R8");
        cyc(8'h20, 0, 0, 1, 1, "R8");
        check({7'd0, start_pulse}, 8'h00, "R8");
        cyc(8'h00, 0, 0, 1, 1, "R11");

        // R9 / R10: exhaustive reselection sweep
        for (int en = 0; en < 4; en++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    for (int fv = 0; fv < 4; fv++) begin
                        logic [7:0] pat;
                        bit ae = en[0];
                        bit ce = en[1];
                        pat = 8'h00;
                        if (fv[0]) pat[a] = 1'b1;
                        if (fv[1]) pat[b] = 1'b1;
                        cyc(8'h00, 1, 3'(a), ae, ce, "R9");
                        cyc(pat, 0, 0, ae, ce, "R4");
                        cyc(pat, 1, 3'(b), ae, ce, "R9");
                        if (!(ae && ce)) cyc(pat, 0, 0, ae, ce, ae ? "R7" : "R6");
                        else if (b == 0) cyc(pat, 0, 0, ae, ce, "R10");
                        else             cyc(pat, 0, 0, ae, ce, "R9");
                        cyc(pat, 0, 0, 1, 1, "R8");
                    end
                end
            end
        end

        // R10: direct case, complete flag high at the switch into code 000
        cyc(8'h00, 1, 3'd6, 1, 1, "R10");
        cyc(8'h01, 0, 0, 1, 1, "R10");
        cyc(8'h01, 1, 3'd0, 1, 1, "R10");
        cyc(8'h01, 0, 0, 1, 1, "R10");
        check({7'd0, start_pulse}, 8'h00, "R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule